// File: doc/BRIEF.md
# Redundant-Tile Voter with Spare Pool Management

This block supervises sixteen identical processor tiles. Three of them run in lockstep as a triple-redundant set that occupies three voting slots, and the other thirteen wait in a spare pool. Each cycle the block compares one observed bus per active tile, for example an instruction address. It registers the majority value, and it raises a one-cycle mismatch pulse that names the slot and tile that disagreed. When all compared values differ, it raises an uncorrectable-error flag instead. A voting disagreement never changes which tiles are in service.

Each tile carries a status code. A hard fault retires a tile for good. A tile can also be taken out for reconfiguration. In both cases the freed slot is refilled with the lowest-numbered spare. A tile that finishes reconfiguration returns to the pool as a spare, and it can be picked again later. When the pool is empty, a freed slot stays empty and the voter works with whatever tiles remain.

A small state machine sequences the slot changes. It has three states:
- RUN: all three slots are full.
- SWAP: a slot is being refilled.
- DEGRADED: a slot is empty and no spare is left.

The transitions are:
- RUN→SWAP on a retire or repair event.
- SWAP→SWAP after it fills one slot.
- SWAP→RUN when no slot is empty.
- SWAP→DEGRADED when a slot is empty and no spare is eligible.
- DEGRADED→SWAP on a new event or when a spare appears.

Top module: `tmr_spare_voter`

## Requirements
- R1: Status is 2 bits per tile at bits [2i+1:2i], coded 0 spare, 1 active, 2 retired (do-not-use), 3 under repair. After reset, tiles 0, 1 and 2 are active in slots 0, 1 and 2, all other tiles are spare, and `pool_empty` is 0.
- R2: With three full slots, when exactly one slot differs from the other two, then one cycle after the inputs are sampled:
  - `voted` holds the value of the two agreeing slots;
  - `mis_pulse` is 1;
  - `mis_slot` and `mis_tile` name the odd slot and its tile.
  When all three agree, `voted` holds the common value and `mis_pulse` is 0.
- R3: When all three slot values differ, `uncorr` is 1, `mis_pulse` is 0, `voted` holds the slot 0 value, and no tile status changes.
- R4: A hard fault on an active tile marks it retired. The slot it held is refilled with the lowest-numbered spare tile whose own fault flag is low, and that tile becomes active.
- R5: A retired tile stays retired for good. It ignores repair start and repair done, and it is never made active again.
- R6: A hard fault on a spare tile marks it retired.
- R7: A repair start that names an active tile, while the controller is in RUN or DEGRADED, marks it under repair and refills its slot like R4. A repair start that names a spare tile is ignored. A repair done that names a tile under repair returns it to spare, not to active.
- R8: `pool_empty` is 1 exactly when no tile is spare. A freed slot with no eligible spare stays empty, and the voter uses the filled slots:
  - two equal values give that value with no flag;
  - two unequal values give `uncorr` with the lower slot's value;
  - one filled slot passes its value through unflagged.
  A spare that appears later fills the lowest empty slot.
- R9: At most three tiles are active at any time, and a tile becomes active only from spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_bus | input | NT*W | Observed bus of every tile, tile i at [i*W +: W] |
| hard_fault | input | NT | Per-tile hard-fault level |
| rep_start_vld | input | 1 | Take the named tile out for reconfiguration |
| rep_start_tile | input | TW | Tile for repair start |
| rep_done_vld | input | 1 | Reconfiguration of the named tile finished |
| rep_done_tile | input | TW | Tile for repair done |
| voted | output | W | Registered voted value |
| mis_pulse | output | 1 | One slot disagreed with the other two |
| mis_slot | output | 2 | Slot that disagreed |
| mis_tile | output | TW | Tile in that slot |
| uncorr | output | 1 | No majority among the filled slots |
| pool_empty | output | 1 | No tile is spare |
| tile_status | output | 2*NT | Per-tile status codes |

## Verification
The assertions check the following on every cycle:
- never more than three active tiles;
- activation only from spare;
- retirement is permanent;
- a tile under repair leaves only toward spare;
- the mismatch and uncorrectable flags are never raised together;
- a mismatch always names a real slot;
- no tile is activated while the pool is empty.

The bench scenarios show the rest:
- the majority value and the slot and tile named for every single-slot corruption;
- the lowest-numbered spare choice, which builds up a scattered active set over repeated faults;
- a repaired tile coming back as a spare and being picked later;
- degraded voting on two slots and then one once the pool is drained.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
    localparam int NSLOT = 3;

    typedef enum logic [1:0] {
        TS_SPARE   = 2'd0,
        TS_ACTIVE  = 2'd1,
        TS_RETIRED = 2'd2,
        TS_REPAIR  = 2'd3
    } tile_st_e;

    typedef enum logic [1:0] {
        C_RUN  = 2'd0,
        C_SWAP = 2'd1,
        C_DEGR = 2'd2
    } ctl_e;
endpackage

// File: rtl/tsv_pick.sv
module tsv_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tsv_vote.sv
module tsv_vote
    import tsv_pkg::*;
#(
    parameter int NT = 16,
    parameter int W  = 8,
    parameter int TW = $clog2(NT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NT*W-1:0]             obs_bus,
    input  logic [NSLOT-1:0][TW-1:0]    slot_tile,
    input  logic [NSLOT-1:0]            slot_vld,
    output logic [W-1:0]                voted,
    output logic                        mis_pulse,
    output logic [1:0]                  mis_slot,
    output logic [TW-1:0]               mis_tile,
    output logic                        uncorr
);
    logic [W-1:0] v [NSLOT];
    logic [W-1:0] val_d;
    logic         mis_d, unc_d;
    logic [1:0]   ms_d;

    for (genvar s = 0; s < NSLOT; s++) begin : g_sel
        always_comb begin
            v[s] = '0;
            for (int t = 0; t < NT; t++) begin
                if (slot_tile[s] == TW'(t)) v[s] = obs_bus[t*W +: W];
            end
        end
    end

    always_comb begin
        val_d = '0;
        mis_d = 1'b0;
        unc_d = 1'b0;
        ms_d  = 2'd0;
        case (slot_vld)
            3'b111: begin
                if (v[0] == v[1]) begin
                    val_d = v[0];
                    if (v[2] != v[0]) begin mis_d = 1'b1; ms_d = 2'd2; end
                end else if (v[0] == v[2]) begin
                    val_d = v[0]; mis_d = 1'b1; ms_d = 2'd1;
                end else if (v[1] == v[2]) begin
                    val_d = v[1]; mis_d = 1'b1; ms_d = 2'd0;
                end else begin
                    val_d = v[0]; unc_d = 1'b1;
                end
            end
            3'b011: begin val_d = v[0]; unc_d = (v[0] != v[1]); end
            3'b101: begin val_d = v[0]; unc_d = (v[0] != v[2]); end
            3'b110: begin val_d = v[1]; unc_d = (v[1] != v[2]); end
            3'b001: val_d = v[0];
            3'b010: val_d = v[1];
            3'b100: val_d = v[2];
            default: unc_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            voted     <= '0;
            mis_pulse <= 1'b0;
            mis_slot  <= 2'd0;
            mis_tile  <= '0;
            uncorr    <= 1'b0;
        end else begin
            voted     <= val_d;
            mis_pulse <= mis_d;
            mis_slot  <= ms_d;
            mis_tile  <= slot_tile[ms_d];
            uncorr    <= unc_d;
        end
    end
endmodule

// File: rtl/tsv_ctrl.sv
module tsv_ctrl
    import tsv_pkg::*;
#(
    parameter int NT = 16,
    parameter int TW = $clog2(NT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NT-1:0]            hard_fault,
    input  logic                     rep_start_vld,
    input  logic [TW-1:0]            rep_start_tile,
    input  logic                     rep_done_vld,
    input  logic [TW-1:0]            rep_done_tile,
    output logic [NSLOT-1:0][TW-1:0] slot_tile,
    output logic [NSLOT-1:0]         slot_vld,
    output logic [2*NT-1:0]          tile_status,
    output logic                     pool_empty
);
    ctl_e     state_q, state_d;
    tile_st_e st_q [NT];
    logic [NT-1:0] spare_vec;
    logic          pick_found;
    logic [TW-1:0] pick_idx;
    logic          ev, ev_hard, empty_found;
    logic [1:0]    ev_slot, empty_slot;

    for (genvar i = 0; i < NT; i++) begin : g_vec
        assign spare_vec[i]          = (st_q[i] == TS_SPARE);
        assign tile_status[2*i +: 2] = st_q[i];
    end
    assign pool_empty = ~|spare_vec;

    tsv_pick #(.N(NT), .IW(TW)) u_pick (
        .cand  (spare_vec & ~hard_fault),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        ev = 1'b0; ev_hard = 1'b0; ev_slot = 2'd0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (slot_vld[s] && rep_start_vld && slot_tile[s] == rep_start_tile) begin
                ev = 1'b1; ev_slot = 2'(s);
            end
        end
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (slot_vld[s] && hard_fault[slot_tile[s]]) begin
                ev = 1'b1; ev_hard = 1'b1; ev_slot = 2'(s);
            end
        end
        empty_found = 1'b0; empty_slot = 2'd0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (!slot_vld[s]) begin empty_found = 1'b1; empty_slot = 2'(s); end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_RUN:  if (ev) state_d = C_SWAP;
            C_SWAP: begin
                if (!empty_found)     state_d = C_RUN;
                else if (!pick_found) state_d = C_DEGR;
            end
            C_DEGR: if (ev || pick_found) state_d = C_SWAP;
            default: state_d = C_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= C_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) st_q[i] <= (i < NSLOT) ? TS_ACTIVE : TS_SPARE;
            for (int s = 0; s < NSLOT; s++) slot_tile[s] <= TW'(s);
            slot_vld <= '1;
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (st_q[i] == TS_SPARE && hard_fault[i]) st_q[i] <= TS_RETIRED;
                if (rep_done_vld && rep_done_tile == TW'(i) && st_q[i] == TS_REPAIR)
                    st_q[i] <= TS_SPARE;
            end
            if ((state_q == C_RUN || state_q == C_DEGR) && ev) begin
                st_q[slot_tile[ev_slot]] <= ev_hard ? TS_RETIRED : TS_REPAIR;
                slot_vld[ev_slot]        <= 1'b0;
            end
            if (state_q == C_SWAP && empty_found && pick_found) begin
                st_q[pick_idx]        <= TS_ACTIVE;
                slot_tile[empty_slot] <= pick_idx;
                slot_vld[empty_slot]  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_spare_voter.sv
module tmr_spare_voter
    import tsv_pkg::*;
#(
    parameter int NT = 16,
    parameter int W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NT*W-1:0]         obs_bus,
    input  logic [NT-1:0]           hard_fault,
    input  logic                    rep_start_vld,
    input  logic [$clog2(NT)-1:0]   rep_start_tile,
    input  logic                    rep_done_vld,
    input  logic [$clog2(NT)-1:0]   rep_done_tile,
    output logic [W-1:0]            voted,
    output logic                    mis_pulse,
    output logic [1:0]              mis_slot,
    output logic [$clog2(NT)-1:0]   mis_tile,
    output logic                    uncorr,
    output logic                    pool_empty,
    output logic [2*NT-1:0]         tile_status
);
    localparam int TW = $clog2(NT);

    logic [NSLOT-1:0][TW-1:0] slot_tile;
    logic [NSLOT-1:0]         slot_vld;

    tsv_ctrl #(.NT(NT), .TW(TW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .hard_fault     (hard_fault),
        .rep_start_vld  (rep_start_vld),
        .rep_start_tile (rep_start_tile),
        .rep_done_vld   (rep_done_vld),
        .rep_done_tile  (rep_done_tile),
        .slot_tile      (slot_tile),
        .slot_vld       (slot_vld),
        .tile_status    (tile_status),
        .pool_empty     (pool_empty)
    );

    tsv_vote #(.NT(NT), .W(W), .TW(TW)) u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .obs_bus   (obs_bus),
        .slot_tile (slot_tile),
        .slot_vld  (slot_vld),
        .voted     (voted),
        .mis_pulse (mis_pulse),
        .mis_slot  (mis_slot),
        .mis_tile  (mis_tile),
        .uncorr    (uncorr)
    );
endmodule

// File: rtl/tsv_chk.sv
module tsv_chk #(
    parameter int NT = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2*NT-1:0] tile_status,
    input logic            mis_pulse,
    input logic [1:0]      mis_slot,
    input logic            uncorr,
    input logic            pool_empty
);
    logic [NT-1:0] act, spr, ret, rep;

    for (genvar i = 0; i < NT; i++) begin : g_t
        assign act[i] = (tile_status[2*i +: 2] == 2'd1);
        assign spr[i] = (tile_status[2*i +: 2] == 2'd0);
        assign ret[i] = (tile_status[2*i +: 2] == 2'd2);
        assign rep[i] = (tile_status[2*i +: 2] == 2'd3);

        // R5: retirement is permanent
        p_retired_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ret[i] |=> ret[i]);
        // R9: activation only from spare
        p_activate_from_spare_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(act[i]) |-> $past(spr[i]));
        // R7: repair exits only to spare
        p_repair_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rep[i] |=> (rep[i] || spr[i]));
    end

    // R9: never more than three active tiles
    p_active_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act) <= 3);
    // R3: mismatch and uncorrectable are exclusive
    p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mis_pulse, uncorr}));
    // R2: a mismatch names a real slot
    p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mis_pulse |-> (mis_slot != 2'd3));
    // R8: nothing is activated while the pool is empty
    p_no_fill_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pool_empty |=> ((act & ~$past(act)) == '0));
endmodule

bind tmr_spare_voter tsv_chk #(.NT(NT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tile_status (tile_status),
    .mis_pulse   (mis_pulse),
    .mis_slot    (mis_slot),
    .uncorr      (uncorr),
    .pool_empty  (pool_empty)
);

// File: tb/sim_tmr_spare_voter.sv
`timescale 1ns/1ps
module sim_tmr_spare_voter;
    localparam int NT = 16;
    localparam int W  = 8;
    localparam int TW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NT*W-1:0] obs_bus = '0;
    logic [NT-1:0]   hard_fault = '0;
    logic            rep_start_vld = 1'b0;
    logic [TW-1:0]   rep_start_tile = '0;
    logic            rep_done_vld = 1'b0;
    logic [TW-1:0]   rep_done_tile = '0;
    logic [W-1:0]    voted;
    logic            mis_pulse, uncorr, pool_empty;
    logic [1:0]      mis_slot;
    logic [TW-1:0]   mis_tile;
    logic [2*NT-1:0] tile_status;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    logic [1:0] exp_st [NT];

    always #4 clk = ~clk;

    tmr_spare_voter #(.NT(NT), .W(W)) u0 (.*);

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_st(string tag);
        logic [2*NT-1:0] e;
        for (int i = 0; i < NT; i++) e[2*i +: 2] = exp_st[i];
        chk(tag, tile_status, e);
    endtask

    task automatic fill(logic [W-1:0] b);
        for (int t = 0; t < NT; t++) obs_bus[t*W +: W] = b;
    endtask

    task automatic put(int t, logic [W-1:0] b);
        obs_bus[t*W +: W] = b;
    endtask

    // inputs already set at a negedge; sample one negedge later
    task automatic vchk(string tag, logic [W-1:0] ev, logic em, logic [1:0] es,
                        logic [TW-1:0] et, logic eu);
        @(negedge clk);
        chk({tag, " voted"}, voted, ev);
        chk({tag, " mis"}, mis_pulse, em);
        chk({tag, " unc"}, uncorr, eu);
        if (em) begin
            chk({tag, " slot"}, mis_slot, es);
            chk({tag, " tile"}, mis_tile, et);
        end
    endtask

    task automatic hf(logic [NT-1:0] m);
        hard_fault = m;
        repeat (3) @(negedge clk);
        hard_fault = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic rstart(int t);
        rep_start_vld = 1'b1; rep_start_tile = TW'(t);
        @(negedge clk);
        rep_start_vld = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic rdone(int t);
        rep_done_vld = 1'b1; rep_done_tile = TW'(t);
        @(negedge clk);
        rep_done_vld = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] bases [3] = '{8'h00, 8'h5A, 8'hFF};
        for (int i = 0; i < NT; i++) exp_st[i] = (i < 3) ? 2'd1 : 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_st("R1 reset status");
        chk("R1 pool_empty", pool_empty, 0);

        // R2: every base, slot and single-bit corruption
        foreach (bases[k]) begin
            fill(bases[k]);
            vchk("R2 agree", bases[k], 0, 0, 0, 0);
            for (int s = 0; s < 3; s++) begin
                for (int b = 0; b < W; b++) begin
                    fill(bases[k]);
                    put(s, bases[k] ^ W'(1 << b));
                    vchk("R2 single", bases[k], 1, 2'(s), TW'(s), 0);
                end
            end
        end

        // R3: three-way disagreement
        fill(8'h00); put(0, 8'h11); put(1, 8'h22); put(2, 8'h33);
        vchk("R3 threeway", 8'h11, 0, 0, 0, 1);
        repeat (3) @(negedge clk);
        chk_st("R3 no retire");
        fill(8'h40);

        // R4: hard fault tile 2 -> tile 3 into slot 2
        hf(16'h0004);
        exp_st[2] = 2'd2; exp_st[3] = 2'd1;
        chk_st("R4 replace 2 by 3");
        fill(8'h40); put(3, 8'h41);
        vchk("R4 new member voted", 8'h40, 1, 2, 3, 0);
        fill(8'h40);

        // R6: faults on spares 4,6,7
        hf(16'h00D0);
        exp_st[4] = 2'd2; exp_st[6] = 2'd2; exp_st[7] = 2'd2;
        chk_st("R6 spare retire");

        // R4: lowest spare picks -> active set 5,8,3
        hf(16'h0001);
        exp_st[0] = 2'd2; exp_st[5] = 2'd1;
        chk_st("R4 replace 0 by 5");
        hf(16'h0002);
        exp_st[1] = 2'd2; exp_st[8] = 2'd1;
        chk_st("R4 replace 1 by 8");
        fill(8'h77); put(8, 8'h70);
        vchk("R4 scattered set", 8'h77, 1, 1, 8, 0);
        fill(8'h77); put(5, 8'h07);
        vchk("R4 scattered slot0", 8'h77, 1, 0, 5, 0);
        fill(8'h77);

        // R7: repair path
        rstart(5);
        exp_st[5] = 2'd3; exp_st[9] = 2'd1;
        chk_st("R7 repair start replaces");
        rdone(5);
        exp_st[5] = 2'd0;
        chk_st("R7 repaired to spare");
        hf(16'h0200);
        exp_st[9] = 2'd2; exp_st[5] = 2'd1;
        chk_st("R7 repaired tile reused");

        // R5 and R7 ignored requests
        rstart(2);
        rdone(2);
        chk_st("R5 retired ignores repair");
        rstart(10);
        chk_st("R7 spare ignores repair start");

        // R8: drain the pool
        hf(16'hFC00);
        for (int i = 10; i < 16; i++) exp_st[i] = 2'd2;
        chk_st("R8 pool drained");
        chk("R8 pool_empty set", pool_empty, 1);
        hf(16'h0100);
        exp_st[8] = 2'd2;
        chk_st("R8 slot left empty");
        fill(8'h33);
        vchk("R8 two agree", 8'h33, 0, 0, 0, 0);
        put(5, 8'h01); put(3, 8'h02);
        vchk("R8 two differ", 8'h01, 0, 0, 0, 1);
        rstart(3);
        exp_st[3] = 2'd3;
        chk_st("R8 repair in degraded");
        fill(8'hC3); put(5, 8'h5C);
        vchk("R8 single pass", 8'h5C, 0, 0, 0, 0);
        rdone(3);
        exp_st[3] = 2'd1;
        chk_st("R8 refill from repaired");
        chk("R8 pool_empty again", pool_empty, 1);
        fill(8'h11); put(3, 8'h12);
        vchk("R8 refilled pair", 8'h11, 0, 0, 0, 1);
        put(3, 8'h11);
        vchk("R8 refilled agree", 8'h11, 0, 0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule